// File: doc/BRIEF.md
# Periodic Timer with Square-Wave and PWM Pin

This block is a free-running up-counter with one waveform pin and one sticky event flag. Software programs it through a single-cycle write port that reaches three registers: a control word, a period (reload) value and a compare value. A power-of-four prescaler sets the counting rate. Each prescaled tick moves the counter forward by one, and the counter returns to zero when a period completes.

The pin has two kinds of use. In square-wave mode it flips on every completed period, so it gives a 50% duty clock at tick rate / (2 × period). In the three compare-based modes it acts as a PWM or toggle output, driven by compare matches, zero crossings and end-of-period events. Each of these modes has a defined pin level while the timer is stopped. The event flag marks every completed period and stays set until software clears it.

Top module: `tmr_waveout`

## Requirements
- R1: After synchronous reset, count_o is 0, wave_o is 0 and irq_o is 0. The run bit, all mode fields, the period and the compare value are also 0.
- R2: When wr_en is high, wr_sel picks the register: 0 is the control word, 1 the period, 2 the compare value. A write with wr_sel 3 changes nothing. The control fields are: bit 0 run, bit 1 square-wave enable, bit 2 event flag, bits [5:3] prescale select, bits [7:6] pin mode.
- R3: While running, the prescaler issues one tick every 4^S clock cycles, where S is the prescale select. The first tick comes 4^S cycles after the write that sets run.
- R4: With a period P of 1 or more, count_o takes the values 0, 1, …, P-1 and then 0 again, one step per tick. The tick that finds the count at P-1 is the end-of-period event.
- R5: A period of 0 holds count_o at 0. It produces no end-of-period events, so the flag is not set and a square-wave pin keeps its level.
- R6: Each end-of-period event sets irq_o on the next cycle. irq_o then stays set until a control-word write with bit 2 at 0. A control write puts bit 2 into the flag, but an end-of-period event in the same cycle leaves the flag set.
- R7: With pin mode 00 and square-wave enable set, wave_o inverts on every end-of-period event, so its period is 2·P ticks. With pin mode 00 and the enable clear, wave_o holds its level.
- R8: Pin mode 01: a tick with count equal to the compare value drives wave_o to 0. A tick with count 0 (and no compare match) drives it to 1. While stopped, wave_o is 0.
- R9: Pin mode 10: a tick with count equal to the compare value drives wave_o to 1. An end-of-period event without a compare match drives it to 0. While stopped, wave_o is 1.
- R10: Pin mode 11: wave_o inverts on each tick whose count equals the compare value. While stopped, wave_o keeps its level.
- R11: When run is 0 at a clock edge, the prescaler and count_o are 0 after that edge. They stay at 0 while run is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 period, 2 compare, 3 none) |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| wave_o | output | 1 | Waveform pin |
| irq_o | output | 1 | Sticky end-of-period flag |

## Verification
The assertions check several things on every cycle: that a stopped timer clears its count, that a zero period freezes it, and that the count stays below an unchanged period. They also check that the flag is sticky and is set by every wrap, that the modes 01 and 10 force their idle pin levels, and that the square-wave pin changes only when the count wraps to zero. Three results need the bench's scenarios: the exact pin level after a given number of ticks in each mode, the prescaled tick spacing, and the race between a flag-clearing write and a wrap in the same cycle. The bench also checks that the unused select writes nothing.

// File: rtl/tmr_waveout_pkg.sv
package tmr_waveout_pkg;
  typedef enum logic [1:0] {
    WM_NONE = 2'b00,
    WM_CLR  = 2'b01,
    WM_SET  = 2'b10,
    WM_TOG  = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam int CTL_RUN    = 0;
  localparam int CTL_SQEN   = 1;
  localparam int CTL_FLAG   = 2;
  localparam int CTL_PS_LSB = 3;
  localparam int CTL_MD_LSB = 6;
  localparam int CTL_MIN_W  = 8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 3,
  localparam int CW = 2 * ((1 << PS_W) - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  logic [CW-1:0] pre_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < 2 * int'(psel)) lim[i] = 1'b1;
    end
  end

  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + CW'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic per_nz;

  assign per_nz = (period != '0);
  assign wrap   = tick && per_nz && (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt <= '0;
    else if (wrap)          cnt <= '0;
    else if (tick && per_nz) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_waveout_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sq_en,
  input  wmode_e           mode,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             wave
);
  logic cmp_hit;
  logic zero_hit;

  assign cmp_hit  = tick && (cnt == cmp);
  assign zero_hit = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else if (!run) begin
      case (mode)
        WM_CLR:  wave <= 1'b0;
        WM_SET:  wave <= 1'b1;
        default: wave <= wave;
      endcase
    end else begin
      case (mode)
        WM_NONE: if (sq_en && wrap) wave <= ~wave;
        WM_CLR: begin
          if (cmp_hit)       wave <= 1'b0;
          else if (zero_hit) wave <= 1'b1;
        end
        WM_SET: begin
          if (cmp_hit)   wave <= 1'b1;
          else if (wrap) wave <= 1'b0;
        end
        WM_TOG:  if (cmp_hit) wave <= ~wave;
        default: wave <= wave;
      endcase
    end
  end
endmodule

// File: rtl/tmr_waveout.sv
module tmr_waveout
  import tmr_waveout_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             wave_o,
  output logic             irq_o
);
  localparam int PS_MSB = CTL_PS_LSB + PS_W - 1;
  localparam int MD_MSB = CTL_MD_LSB + 1;

  logic            run_q;
  logic            sq_en_q;
  logic [PS_W-1:0] psel_q;
  wmode_e          mode_q;
  logic            flag_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cmp_q;

  logic ctl_wr;
  logic per_wr;
  logic cmp_wr;
  logic tick;
  logic wrap;

  assign ctl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
  assign per_wr = wr_en && (wsel_e'(wr_sel) == SEL_PER);
  assign cmp_wr = wr_en && (wsel_e'(wr_sel) == SEL_CMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      sq_en_q <= 1'b0;
      psel_q  <= '0;
      mode_q  <= WM_NONE;
      per_q   <= '0;
      cmp_q   <= '0;
    end else begin
      if (ctl_wr) begin
        run_q   <= wr_data[CTL_RUN];
        sq_en_q <= wr_data[CTL_SQEN];
        psel_q  <= wr_data[PS_MSB:CTL_PS_LSB];
        mode_q  <= wmode_e'(wr_data[MD_MSB:CTL_MD_LSB]);
      end
      if (per_wr) per_q <= wr_data;
      if (cmp_wr) cmp_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (wrap)   flag_q <= 1'b1;
    else if (ctl_wr) flag_q <= wr_data[CTL_FLAG];
  end

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run_q),
    .psel (psel_q),
    .tick (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .tick   (tick),
    .period (per_q),
    .cnt    (count_o),
    .wrap   (wrap)
  );

  tmr_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .sq_en (sq_en_q),
    .mode  (mode_q),
    .tick  (tick),
    .wrap  (wrap),
    .cnt   (count_o),
    .cmp   (cmp_q),
    .wave  (wave_o)
  );

  assign irq_o = flag_q;
endmodule

// File: rtl/tmr_waveout_chk.sv
module tmr_waveout_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             run,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] period,
  input logic             tick,
  input logic [CNT_W-1:0] count_o,
  input logic             wave_o,
  input logic             irq_o
);
  AST_STOP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !run |=> count_o == '0); // R11
  AST_ZERO_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (period == '0 && count_o == '0) |=> count_o == '0); // R5
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (run && period != '0 && count_o < period && !(wr_en && wr_sel == 2'd1))
    |=> count_o < period); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !(wr_en && wr_sel == 2'd0)) |=> irq_o); // R6
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && period != '0 && count_o == period - CNT_W'(1)) |=> (irq_o && count_o == '0)); // R6
  AST_CLR_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!run && mode == 2'b01) |=> !wave_o); // R8
  AST_SET_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!run && mode == 2'b10) |=> wave_o); // R9
  AST_SQ_EDGE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && mode == 2'b00) |=> ($stable(wave_o) || count_o == '0)); // R7
endmodule

bind tmr_waveout tmr_waveout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .run     (run_q),
  .mode    (mode_q),
  .period  (per_q),
  .tick    (tick),
  .count_o (count_o),
  .wave_o  (wave_o),
  .irq_o   (irq_o)
);

// File: tb/sim_tmr_waveout.sv
module sim_tmr_waveout;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] cmp;
    logic [15:0] ctl;
    logic [15:0] n;
    logic [15:0] ecnt;
    logic        ewave;
    logic        eirq;
  } vec_t;

  // ctl: bit1 square enable, bits[5:3] prescale, bits[7:6] pin mode
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'd5, 16'd0, 16'h0002, 16'd12, 16'd2, 1'b0, 1'b1}, // R7 R4
    '{16'd5, 16'd0, 16'h0002, 16'd7,  16'd2, 1'b1, 1'b1}, // R7
    '{16'd3, 16'd0, 16'h0002, 16'd2,  16'd2, 1'b0, 1'b0}, // R4
    '{16'd2, 16'd0, 16'h000A, 16'd13, 16'd1, 1'b1, 1'b1}, // R3
    '{16'd8, 16'd3, 16'h0040, 16'd10, 16'd2, 1'b1, 1'b1}, // R8
    '{16'd8, 16'd3, 16'h0040, 16'd13, 16'd5, 1'b0, 1'b1}, // R8
    '{16'd8, 16'd3, 16'h0080, 16'd13, 16'd5, 1'b1, 1'b1}, // R9
    '{16'd8, 16'd3, 16'h0080, 16'd16, 16'd0, 1'b0, 1'b1}, // R9
    '{16'd8, 16'd3, 16'h0080, 16'd2,  16'd2, 1'b1, 1'b0}, // R9
    '{16'd6, 16'd2, 16'h00C0, 16'd9,  16'd3, 1'b0, 1'b1}, // R10
    '{16'd6, 16'd2, 16'h00C0, 16'd5,  16'd5, 1'b1, 1'b0}, // R10
    '{16'd0, 16'd0, 16'h0002, 16'd20, 16'd0, 1'b0, 1'b0}, // R5
    '{16'd2, 16'd0, 16'h0000, 16'd7,  16'd1, 1'b0, 1'b1}, // R7
    '{16'd3, 16'd0, 16'h0012, 16'd50, 16'd0, 1'b1, 1'b1}  // R3
  };
  localparam string VREQ [NV] = '{"R7", "R7", "R4", "R3", "R8", "R8", "R9",
                                  "R9", "R9", "R10", "R10", "R5", "R7", "R3"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] count_o;
  logic             wave_o;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  tmr_waveout #(.CNT_W(CNT_W), .PS_W(3)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count_o(count_o), .wave_o(wave_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
  endtask

  task automatic setup_run(input logic [15:0] per, input logic [15:0] cmp, input logic [15:0] ctl);
    wr(2'd0, 16'h0040);        // stopped, mode 01: pin forced low
    wr(2'd0, ctl);             // stopped in target mode
    wr(2'd1, per);
    wr(2'd2, cmp);
    wr(2'd0, ctl | 16'h0001);  // run
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "count after reset", int'(count_o), 0);
    chk("R1", "wave after reset", int'(wave_o), 0);
    chk("R1", "flag after reset", int'(irq_o), 0);

    for (int v = 0; v < NV; v++) begin
      setup_run(VECS[v].per, VECS[v].cmp, VECS[v].ctl);
      repeat (int'(VECS[v].n)) @(negedge clk);
      chk(VREQ[v], $sformatf("vec%0d count", v), int'(count_o), int'(VECS[v].ecnt));
      chk(VREQ[v], $sformatf("vec%0d wave", v), int'(wave_o), int'(VECS[v].ewave));
      chk("R6", $sformatf("vec%0d flag", v), int'(irq_o), int'(VECS[v].eirq));
    end

    // R11: stopping clears the count one cycle after the write; mode 10 idles high
    setup_run(16'd8, 16'd3, 16'h0080);
    repeat (5) @(negedge clk);
    wr(2'd0, 16'h0080);
    @(negedge clk);
    chk("R11", "count after stop", int'(count_o), 0);
    chk("R9", "idle level mode 10", int'(wave_o), 1);
    repeat (4) @(negedge clk);
    chk("R11", "count held while stopped", int'(count_o), 0);

    // R6: clearing write, then a clearing write racing a wrap
    setup_run(16'd5, 16'd0, 16'h0002);
    repeat (6) @(negedge clk);
    wr(2'd0, 16'h0003);
    chk("R6", "flag cleared by write", int'(irq_o), 0);
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0003);
    chk("R6", "flag kept on wrap vs clear", int'(irq_o), 1);
    chk("R4", "count wrapped", int'(count_o), 0);
    chk("R7", "square after two wraps", int'(wave_o), 0);

    // R6: software set while stopped
    wr(2'd0, 16'h0000);
    chk("R6", "flag cleared when stopped", int'(irq_o), 0);
    wr(2'd0, 16'h0004);
    chk("R6", "flag set by write", int'(irq_o), 1);
    wr(2'd0, 16'h0000);
    chk("R6", "flag cleared again", int'(irq_o), 0);

    // R2: select 3 writes nothing
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'd4);
    wr(2'd3, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R2", "select 3 did not start", int'(count_o), 0);
    chk("R2", "select 3 pin unchanged", int'(wave_o), 0);
    wr(2'd0, 16'h0003);
    repeat (5) @(negedge clk);
    chk("R2", "period kept after select 3", int'(count_o), 1);
    chk("R7", "square after one wrap", int'(wave_o), 1);

    finish_run();
  end
endmodule